// File: doc/BRIEF.md
# YCbCr 4:2:2 Byte-Stream Demultiplexer

This block takes a multiplexed 4:2:2 YCbCr stream, one 8-bit byte per clock, and splits it into separate components. The byte phase is set by the falling edge of an active-low horizontal sync. Luma leaves at half the byte rate with its own one-cycle strobe. Blue-difference and red-difference chroma leave together as a co-sited pair at a quarter of the byte rate, marked by a second strobe. The pair is presented only once both of its components have arrived.

Two static configuration inputs change the slot layout. One swaps which chroma component comes first. The other moves luma from the odd slots to the even slots. The two swaps can be used in any combination. Each component is clamped to its legal code range. Chroma is then moved to a signed value centred on zero, ready for interpolation and modulation stages further down the pipeline.

Top module: `ycd_demux`

## Requirements
- R1: While rst_ni is low, y_valid_o and c_valid_o are 0 and y_o, cb_o and cr_o are 0.
- R2: After reset, no strobe is raised until the first falling edge of hsync_ni has been sampled. A falling edge is a clock edge that samples hsync_ni low when the previous edge sampled it high.
- R3: The byte sampled on the edge that detects the falling edge is discarded and produces no strobe. The byte sampled on the next edge is slot 0, and the slots then count 0,1,2,3 and repeat.
- R4: With both swaps low, the slots carry Cb, Y, Cr, Y. Each result is registered on the edge that samples its byte and is visible for the following cycle.
- R5: With cb_cr_swap_i high (and y_c_swap_i low), the slots carry Cr, Y, Cb, Y.
- R6: With y_c_swap_i high, the slots carry Y, first chroma, Y, second chroma. The first chroma is Cb when cb_cr_swap_i is low and Cr when it is high.
- R7: y_valid_o pulses for one cycle for every luma slot. y_o is the byte clamped to 16..235 and changes only together with y_valid_o.
- R8: cb_o and cr_o are the chroma bytes clamped to 16..240 and reduced by 128, given as 8-bit two's complement (range -112..112).
- R9: c_valid_o pulses for one cycle on the second chroma slot of a pair, with cb_o and cr_o updated together. Two such pulses are always at least four cycles apart, and c_valid_o never coincides with y_valid_o.
- R10: A new falling edge of hsync_ni restarts the slot count immediately, even in the middle of a pattern. Any first chroma component still waiting for its partner is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock, twice the luma rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_ni | input | 1 | Horizontal sync, active low; its falling edge aligns the slots |
| data_i | input | 8 | Multiplexed YCbCr byte |
| cb_cr_swap_i | input | 1 | Exchange the order of Cb and Cr |
| y_c_swap_i | input | 1 | Place luma on even slots and chroma on odd slots |
| y_o | output | 8 | Clamped luma sample |
| y_valid_o | output | 1 | One-cycle strobe for a new y_o |
| cb_o | output | 8 | Signed Cb, offset removed |
| cr_o | output | 8 | Signed Cr, offset removed |
| c_valid_o | output | 1 | One-cycle strobe for a new Cb/Cr pair |

## Verification
The assertions assume that hsync_ni is synchronous to clk_i. They also assume that each low sync pulse is preceded by at least one sampled high level, so that every line start is seen as a single clean falling edge. The swap inputs are assumed to stay constant within a line. The stimulus changes the swaps only on the cycle that drives the sync low, and raises the sync again partway through each line. Line lengths that are not multiples of four force restarts in the middle of a pattern. Every byte is driven on the falling clock edge, so capture never races the drive.

// File: rtl/ycd_pkg.sv
package ycd_pkg;
  localparam int unsigned PHASES = 4;
  localparam int unsigned PH_W   = $clog2(PHASES);

  typedef enum logic [1:0] {
    SLOT_LUMA     = 2'd0,
    SLOT_C_FIRST  = 2'd1,
    SLOT_C_SECOND = 2'd2,
    SLOT_NONE     = 2'd3
  } slot_e;
endpackage

// File: rtl/ycd_phase.sv
module ycd_phase
  import ycd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hsync_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            fall_o,
  output logic            capture_o
);
  logic            hsync_q;
  logic            active_q;
  logic [PH_W-1:0] phase_q;

  assign fall_o    = hsync_q & ~hsync_ni;
  assign capture_o = active_q & ~fall_o;
  assign phase_o   = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_q  <= 1'b1;
      active_q <= 1'b0;
      phase_q  <= '0;
    end else begin
      hsync_q <= hsync_ni;
      if (fall_o) begin
        phase_q  <= '0;
        active_q <= 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ycd_slot_decode.sv
module ycd_slot_decode
  import ycd_pkg::*;
(
  input  logic [PH_W-1:0] phase_i,
  input  logic            y_c_swap_i,
  input  logic            cb_cr_swap_i,
  output slot_e           slot_o,
  output logic            is_cr_o
);
  logic luma_slot;
  logic first_slot;

  // luma on odd phases normally, even phases when swapped
  assign luma_slot  = y_c_swap_i ? ~phase_i[0] : phase_i[0];
  assign first_slot = ~phase_i[1];

  always_comb begin
    if (luma_slot)       slot_o = SLOT_LUMA;
    else if (first_slot) slot_o = SLOT_C_FIRST;
    else                 slot_o = SLOT_C_SECOND;
  end

  // first chroma is Cb unless swapped; second is the other one
  assign is_cr_o = first_slot ? cb_cr_swap_i : ~cb_cr_swap_i;
endmodule

// File: rtl/ycd_clamp.sv
module ycd_clamp #(
  parameter int unsigned W      = 8,
  parameter int unsigned LO     = 16,
  parameter int unsigned HI     = 235,
  parameter int unsigned OFFSET = 0
) (
  input  logic [W-1:0] code_i,
  output logic [W-1:0] value_o
);
  localparam logic [W-1:0] LO_V  = LO[W-1:0];
  localparam logic [W-1:0] HI_V  = HI[W-1:0];
  localparam logic [W-1:0] OFF_V = OFFSET[W-1:0];

  logic [W-1:0] sat;

  always_comb begin
    if (code_i < LO_V)      sat = LO_V;
    else if (code_i > HI_V) sat = HI_V;
    else                    sat = code_i;
  end

  assign value_o = sat - OFF_V;
endmodule

// File: rtl/ycd_demux.sv
module ycd_demux
  import ycd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned Y_LO   = 16,
  parameter int unsigned Y_HI   = 235,
  parameter int unsigned C_LO   = 16,
  parameter int unsigned C_HI   = 240,
  parameter int unsigned C_ZERO = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cb_cr_swap_i,
  input  logic              y_c_swap_i,
  output logic [DATA_W-1:0] y_o,
  output logic              y_valid_o,
  output logic [DATA_W-1:0] cb_o,
  output logic [DATA_W-1:0] cr_o,
  output logic              c_valid_o
);
  logic [PH_W-1:0]   phase;
  logic              fall;
  logic              capture;
  slot_e             slot;
  logic              is_cr;
  logic [DATA_W-1:0] y_val;
  logic [DATA_W-1:0] c_val;

  logic [DATA_W-1:0] y_q, cb_q, cr_q, hold_q;
  logic              y_vld_q, c_vld_q, hold_vld_q;

  ycd_phase u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hsync_ni  (hsync_ni),
    .phase_o   (phase),
    .fall_o    (fall),
    .capture_o (capture)
  );

  ycd_slot_decode u_slot (
    .phase_i      (phase),
    .y_c_swap_i   (y_c_swap_i),
    .cb_cr_swap_i (cb_cr_swap_i),
    .slot_o       (slot),
    .is_cr_o      (is_cr)
  );

  ycd_clamp #(.W(DATA_W), .LO(Y_LO), .HI(Y_HI), .OFFSET(0)) u_y_clamp (
    .code_i  (data_i),
    .value_o (y_val)
  );

  ycd_clamp #(.W(DATA_W), .LO(C_LO), .HI(C_HI), .OFFSET(C_ZERO)) u_c_clamp (
    .code_i  (data_i),
    .value_o (c_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q        <= '0;
      cb_q       <= '0;
      cr_q       <= '0;
      hold_q     <= '0;
      y_vld_q    <= 1'b0;
      c_vld_q    <= 1'b0;
      hold_vld_q <= 1'b0;
    end else begin
      y_vld_q <= 1'b0;
      c_vld_q <= 1'b0;
      if (fall) begin
        hold_vld_q <= 1'b0;
      end else if (capture) begin
        unique case (slot)
          SLOT_LUMA: begin
            y_q     <= y_val;
            y_vld_q <= 1'b1;
          end
          SLOT_C_FIRST: begin
            hold_q     <= c_val;
            hold_vld_q <= 1'b1;
          end
          SLOT_C_SECOND: begin
            if (hold_vld_q) begin
              if (is_cr) begin
                cr_q <= c_val;
                cb_q <= hold_q;
              end else begin
                cb_q <= c_val;
                cr_q <= hold_q;
              end
              c_vld_q <= 1'b1;
            end
            hold_vld_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign y_o       = y_q;
  assign y_valid_o = y_vld_q;
  assign cb_o      = cb_q;
  assign cr_o      = cr_q;
  assign c_valid_o = c_vld_q;
endmodule

// File: rtl/ycd_checker.sv
module ycd_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned Y_LO   = 16,
  parameter int unsigned Y_HI   = 235,
  parameter int unsigned C_LO   = 16,
  parameter int unsigned C_HI   = 240,
  parameter int unsigned C_ZERO = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hsync_ni,
  input logic [DATA_W-1:0] y_o,
  input logic              y_valid_o,
  input logic [DATA_W-1:0] cb_o,
  input logic [DATA_W-1:0] cr_o,
  input logic              c_valid_o
);
  localparam int C_MIN = int'(C_LO) - int'(C_ZERO);
  localparam int C_MAX = int'(C_HI) - int'(C_ZERO);

  logic hs_q;
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q   <= 1'b1;
      seen_q <= 1'b0;
    end else begin
      hs_q <= hsync_ni;
      if (hs_q && !hsync_ni) seen_q <= 1'b1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_quiet_r1: assert (!y_valid_o && !c_valid_o);
  end

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (!y_valid_o && !c_valid_o));

  p_fall_discard_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_q && !hsync_ni) |=> (!y_valid_o && !c_valid_o));

  p_luma_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |=> !y_valid_o);

  p_luma_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |-> (int'(y_o) >= int'(Y_LO) && int'(y_o) <= int'(Y_HI)));

  p_luma_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !y_valid_o |-> $stable(y_o));

  p_chroma_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_valid_o |-> ($signed(cb_o) >= C_MIN && $signed(cb_o) <= C_MAX &&
                   $signed(cr_o) >= C_MIN && $signed(cr_o) <= C_MAX));

  p_pair_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_valid_o |-> (!$past(c_valid_o, 1) && !$past(c_valid_o, 2) && !$past(c_valid_o, 3)));

  p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(y_valid_o && c_valid_o));

  p_chroma_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_valid_o |-> ($stable(cb_o) && $stable(cr_o)));
endmodule

bind ycd_demux ycd_checker #(
  .DATA_W(DATA_W), .Y_LO(Y_LO), .Y_HI(Y_HI),
  .C_LO(C_LO), .C_HI(C_HI), .C_ZERO(C_ZERO)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hsync_ni  (hsync_ni),
  .y_o       (y_o),
  .y_valid_o (y_valid_o),
  .cb_o      (cb_o),
  .cr_o      (cr_o),
  .c_valid_o (c_valid_o)
);

// File: tb/tb_ycd_demux.sv
`timescale 1ns/1ps
module tb_ycd_demux;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       hsync_ni;
  logic [7:0] data_i;
  logic       cb_cr_swap_i;
  logic       y_c_swap_i;
  logic [7:0] y_o, cb_o, cr_o;
  logic       y_valid_o, c_valid_o;

  int checks = 0;
  int errors = 0;

  // bench model state
  int       prev_kind = 0;  // 0 idle, 1 discarded fall edge, 2 captured byte
  int       prev_slot = 0;
  logic [7:0] prev_byte = 8'h00;
  logic     cur_ycs = 1'b0, cur_cbs = 1'b0;
  logic     restart_line = 1'b0;
  int       prev_k = 0;
  logic     pend_v = 1'b0;
  logic [7:0] pend_val = 8'h00;
  logic     done = 1'b0;

  always #4 clk_i = ~clk_i;

  ycd_demux dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hsync_ni     (hsync_ni),
    .data_i       (data_i),
    .cb_cr_swap_i (cb_cr_swap_i),
    .y_c_swap_i   (y_c_swap_i),
    .y_o          (y_o),
    .y_valid_o    (y_valid_o),
    .cb_o         (cb_o),
    .cr_o         (cr_o),
    .c_valid_o    (c_valid_o)
  );

  function automatic logic [7:0] luma_ref(input logic [7:0] b);
    if (b < 8'd16) return 8'd16;
    if (b > 8'd235) return 8'd235;
    return b;
  endfunction

  function automatic logic [7:0] chroma_ref(input logic [7:0] b);
    logic [7:0] s;
    s = (b < 8'd16) ? 8'd16 : (b > 8'd240) ? 8'd240 : b;
    return s - 8'd128;
  endfunction

  function automatic logic [7:0] corner(input int i);
    case (i % 11)
      0: return 8'd0;    1: return 8'd15;   2: return 8'd16;
      3: return 8'd17;   4: return 8'd128;  5: return 8'd234;
      6: return 8'd235;  7: return 8'd236;  8: return 8'd240;
      9: return 8'd241;  default: return 8'd255;
    endcase
  endfunction

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // compare outputs produced by the edge that sampled the previously driven byte
  task automatic check_prev();
    logic exp_yv, exp_cv, is_y, first;
    logic [7:0] exp_y, exp_cb, exp_cr;
    string tag;
    exp_yv = 0; exp_cv = 0; exp_y = 0; exp_cb = 0; exp_cr = 0;
    tag = cur_ycs ? "R6" : (cur_cbs ? "R5" : "R4");
    if (prev_kind == 0) tag = "R2";
    if (prev_kind == 1) begin
      tag = "R3";
      pend_v = 0;
    end
    if (prev_kind == 2) begin
      if (restart_line && prev_k < 4) tag = "R10";
      is_y  = cur_ycs ? ~prev_slot[0] : prev_slot[0];
      first = cur_ycs ? (prev_slot == 1) : (prev_slot == 0);
      if (is_y) begin
        exp_yv = 1; exp_y = luma_ref(prev_byte);
      end else if (first) begin
        pend_v = 1; pend_val = chroma_ref(prev_byte);
      end else if (pend_v) begin
        exp_cv = 1;
        if (cur_cbs) begin exp_cb = chroma_ref(prev_byte); exp_cr = pend_val; end
        else         begin exp_cr = chroma_ref(prev_byte); exp_cb = pend_val; end
        pend_v = 0;
      end
    end
    check_eq(tag, "y_valid_o", int'(y_valid_o), int'(exp_yv));
    check_eq(exp_cv ? "R9" : tag, "c_valid_o", int'(c_valid_o), int'(exp_cv));
    if (exp_yv && y_valid_o) check_eq("R7", "y_o", int'(y_o), int'(exp_y));
    if (exp_cv && c_valid_o) begin
      check_eq("R8", "cb_o", int'(cb_o), int'(exp_cb));
      check_eq("R8", "cr_o", int'(cr_o), int'(exp_cr));
    end
  endtask

  task automatic run_line(input logic ycs, input logic cbs, input int n, input logic directed);
    @(negedge clk_i);
    check_prev();
    hsync_ni = 1'b0;
    cb_cr_swap_i = cbs;
    y_c_swap_i = ycs;
    data_i = 8'($urandom_range(0, 255));
    prev_kind = 1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      check_prev();
      cur_ycs = ycs;
      cur_cbs = cbs;
      data_i = directed ? corner(k) : 8'($urandom_range(0, 255));
      if (k == 6) hsync_ni = 1'b1;
      prev_kind = 2;
      prev_slot = k % 4;
      prev_byte = data_i;
      prev_k = k;
    end
    restart_line = (n % 4) != 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c42));
    rst_ni = 1'b0;
    hsync_ni = 1'b1;
    data_i = 8'h00;
    cb_cr_swap_i = 1'b0;
    y_c_swap_i = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check_eq("R1", "y_valid_o", int'(y_valid_o), 0);
    check_eq("R1", "c_valid_o", int'(c_valid_o), 0);
    check_eq("R1", "y_o", int'(y_o), 0);
    check_eq("R1", "cb_o", int'(cb_o), 0);
    check_eq("R1", "cr_o", int'(cr_o), 0);
    rst_ni = 1'b1;
    // R2: bytes with sync held high give no strobes
    prev_kind = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      check_prev();
      data_i = corner(i);
    end
    // directed patterns across swap combinations and clamp corners
    run_line(1'b0, 1'b0, 24, 1'b1);
    run_line(1'b0, 1'b1, 24, 1'b1);
    run_line(1'b1, 1'b0, 24, 1'b1);
    run_line(1'b1, 1'b1, 24, 1'b1);
    // R10: lengths that end mid-pattern, including a dangling first chroma
    run_line(1'b0, 1'b0, 9, 1'b0);
    run_line(1'b0, 1'b0, 10, 1'b0);
    run_line(1'b1, 1'b0, 11, 1'b0);
    run_line(1'b1, 1'b1, 14, 1'b0);
    // constrained random lines
    for (int l = 0; l < 60; l++)
      run_line(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               $urandom_range(8, 40), 1'($urandom_range(0, 3) == 0));
    @(negedge clk_i);
    check_prev();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule